// File: doc/BRIEF.md
# Decoded Micro-Op Line Cache

This block keeps already-decoded micro-ops so that a front end can replay a hot code window without decoding it again. It is set-associative and is indexed by the virtual window number, which is the fetch address with its low five bits removed. No translation is needed to look something up. A fill begins with a start pulse that names the window. Decoded instructions then arrive one per cycle. Each carries a micro-op count, a flag for an unconditional or predicted-taken branch, and up to six opaque 16-bit tokens.

A packer places the instructions into at most three line buffers. It obeys the placement rules: one instruction is never split across lines, a line never holds more than six micro-ops, and a branch closes its line. When the last instruction arrives, the whole window is written into ways chosen by tree pseudo-LRU, or nothing is written at all. A window that breaks a rule is dropped.

A lookup names a window and a line number within it. One line is read per cycle, and the result appears on the next cycle. A single invalidate input empties the whole cache and abandons any fill in progress.

Top module: `uop_cache`

## Requirements
- R1: After reset, every lookup misses.
- R2: The set is the low 5 bits of the window number and the tag is the remaining 22 bits. A window with the same set but a different tag misses.
- R3: A line holds 1 to 6 micro-ops. An instruction whose count does not fit in the current line starts the next line, so one instruction's micro-ops never split across lines.
- R4: An instruction with the branch flag set closes its line. The next instruction starts a new line, and the line reports the branch flag on lookup.
- R5: A window may use at most 3 lines. A window that would need a fourth line is dropped, and any lines already cached for that window are left unchanged.
- R6: A lookup presented in cycle t returns, after the clock edge that ends cycle t, these fields: the hit flag, the line's count, its branch flag, a last-line flag, and its tokens with slot 0 in bits 15:0. Two back-to-back lookups return two lines on two consecutive cycles. A cycle with no lookup returns a miss.
- R7: A completed window writes all of its lines into distinct ways of its set, in one cycle. Re-filling a cached window first removes all of its old lines.
- R8: Ways are replaced by tree pseudo-LRU. If no lookups intervene, a ninth single-line window filled into a full set evicts the window that was filled first.
- R9: Invalidate clears every line. A fill that is in progress when invalidate arrives is abandoned, so its window stays uncached.
- R10: An instruction count of 0 or more than 6 causes the whole window to be dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fl_start | input | 1 | Opens a new fill window |
| fl_win | input | 27 | Window number of the fill |
| fl_ins | input | 1 | A decoded instruction is presented |
| fl_cnt | input | 3 | Micro-op count of the instruction |
| fl_br | input | 1 | Instruction ends in a taken or unconditional branch |
| fl_end | input | 1 | Last instruction of the window |
| fl_uops | input | 96 | Instruction tokens, slot 0 in bits 15:0 |
| inv | input | 1 | Clear the whole cache |
| lk_valid | input | 1 | Lookup request |
| lk_win | input | 27 | Window number to look up |
| lk_seq | input | 2 | Line number within the window (0 to 2) |
| rd_hit | output | 1 | Registered lookup hit |
| rd_cnt | output | 3 | Micro-ops in the returned line |
| rd_br | output | 1 | Returned line was closed by a branch |
| rd_last | output | 1 | Returned line is the last line of its window |
| rd_uops | output | 96 | Returned tokens |

## Verification
Several properties are checked by assertions on every cycle:
- a lookup matches at most one way;
- packer line counts stay within six, and its line cursor stays within three;
- each window commits only once;
- the victims chosen for one window are distinct ways;
- a hit never reports an empty line;
- invalidation is followed by misses.

Other behaviour can only be shown by the bench scenarios. These include where instructions land after a split or a branch, the contents of the tokens, keeping old lines after a rejected fill, dropping stale lines on a re-fill, and which window pseudo-LRU evicts.

// File: rtl/uc_pkg.sv
package uc_pkg;
    parameter int UC_VA_W      = 32;
    parameter int UC_WIN_BYTES = 32;
    parameter int UC_SETS      = 32;
    parameter int UC_WAYS      = 8;
    parameter int UC_SLOTS     = 6;
    parameter int UC_MAXL      = 3;
    parameter int UC_UOP_W     = 16;

    localparam int OFF_W = $clog2(UC_WIN_BYTES);
    localparam int WIN_W = UC_VA_W - OFF_W;
    localparam int IDX_W = $clog2(UC_SETS);
    localparam int TAG_W = WIN_W - IDX_W;
    localparam int WAY_W = $clog2(UC_WAYS);
    localparam int CNT_W = $clog2(UC_SLOTS + 1);
    localparam int SEQ_W = $clog2(UC_MAXL);

    typedef logic [UC_SLOTS-1:0][UC_UOP_W-1:0] toks_t;

    typedef struct packed {
        logic             br;
        logic [CNT_W-1:0] cnt;
        toks_t            toks;
    } line_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SEQ_W-1:0] seq;
        logic             last;
        line_t            line;
    } ent_t;

    // Tree walk: node bit 1 sends the search to the right child.
    function automatic logic [WAY_W-1:0] plru_pick(input logic [UC_WAYS-1:0] t);
        int n;
        n = 1;
        for (int l = 0; l < WAY_W; l++) n = 2 * n + (t[n] ? 1 : 0);
        return WAY_W'(n - UC_WAYS);
    endfunction

    // Mark a way as most recent: every node on its path points away from it.
    function automatic logic [UC_WAYS-1:0] plru_touch(input logic [UC_WAYS-1:0] t,
                                                      input logic [WAY_W-1:0] w);
        logic [UC_WAYS-1:0] r;
        int n;
        r = t;
        n = int'(w) + UC_WAYS;
        for (int l = 0; l < WAY_W; l++) begin
            r[n / 2] = (n % 2 == 0);
            n = n / 2;
        end
        return r;
    endfunction
endpackage

// File: rtl/uc_packer.sv
module uc_packer
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inv,
    input  logic             start,
    input  logic [WIN_W-1:0] start_win,
    input  logic             ins,
    input  logic [CNT_W-1:0] cnt,
    input  logic             br,
    input  logic             last,
    input  toks_t            toks,
    output logic             cm_valid,
    output logic [WIN_W-1:0] cm_win,
    output logic [SEQ_W-1:0] cm_lines,
    output line_t            cm_buf [UC_MAXL]
);
    line_t            buf_q [UC_MAXL];
    line_t            buf_d [UC_MAXL];
    logic [SEQ_W-1:0] cur_q, cur_d;
    logic             closed_q, closed_d;
    logic             rej_q, rej_d;
    logic             cmv_q, cmv_d;
    logic [WIN_W-1:0] win_q;
    int               base_i, cnt_i, put_i, tgt_i;
    logic             newl, bad;

    always_comb begin
        buf_d    = buf_q;
        cur_d    = cur_q;
        closed_d = closed_q;
        rej_d    = rej_q;
        cmv_d    = 1'b0;
        base_i   = int'(buf_q[cur_q].cnt);
        cnt_i    = int'(cnt);
        newl     = (base_i != 0) && (closed_q || (base_i + cnt_i > UC_SLOTS));
        tgt_i    = int'(cur_q) + (newl ? 1 : 0);
        put_i    = newl ? 0 : base_i;
        bad      = (cnt_i == 0) || (cnt_i > UC_SLOTS) || (tgt_i >= UC_MAXL);
        if (inv) begin
            rej_d = 1'b1;
        end else if (start) begin
            for (int l = 0; l < UC_MAXL; l++) begin
                buf_d[l].cnt = '0;
                buf_d[l].br  = 1'b0;
            end
            cur_d    = '0;
            closed_d = 1'b0;
            rej_d    = 1'b0;
        end else if (ins && !rej_q) begin
            if (bad) begin
                rej_d = 1'b1;
            end else begin
                for (int s = 0; s < UC_SLOTS; s++)
                    if (s >= put_i && s < put_i + cnt_i)
                        buf_d[tgt_i].toks[s] = toks[s - put_i];
                buf_d[tgt_i].cnt = CNT_W'(put_i + cnt_i);
                buf_d[tgt_i].br  = br;
                closed_d         = br;
                cur_d            = SEQ_W'(tgt_i);
                if (last) begin
                    cmv_d = 1'b1;
                    rej_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < UC_MAXL; l++) buf_q[l] <= '0;
            cur_q    <= '0;
            closed_q <= 1'b0;
            rej_q    <= 1'b1;
            cmv_q    <= 1'b0;
            win_q    <= '0;
        end else begin
            buf_q    <= buf_d;
            cur_q    <= cur_d;
            closed_q <= closed_d;
            rej_q    <= rej_d;
            cmv_q    <= cmv_d;
            if (start && !inv) win_q <= start_win;
        end
    end

    assign cm_valid = cmv_q;
    assign cm_win   = win_q;
    assign cm_lines = cur_q + SEQ_W'(1);
    assign cm_buf   = buf_q;

    a_r5_cur_in_range: assert property (@(posedge clk) disable iff (rst)
        cur_q < SEQ_W'(UC_MAXL));
    a_r7_single_commit: assert property (@(posedge clk) disable iff (rst)
        cmv_q |=> !cmv_q);
    for (genvar l = 0; l < UC_MAXL; l++) begin : g_cap
        a_r3_line_cap: assert property (@(posedge clk) disable iff (rst)
            int'(buf_q[l].cnt) <= UC_SLOTS);
    end
endmodule

// File: rtl/uc_repl.sv
module uc_repl
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cm_valid,
    input  logic [IDX_W-1:0] cm_set,
    input  logic [SEQ_W-1:0] cm_lines,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] vict [UC_MAXL]
);
    logic [UC_WAYS-1:0] tree_q [UC_SETS];
    logic [UC_WAYS-1:0] chain  [UC_MAXL+1];

    always_comb begin
        chain[0] = tree_q[cm_set];
        for (int k = 0; k < UC_MAXL; k++) begin
            vict[k]    = plru_pick(chain[k]);
            chain[k+1] = plru_touch(chain[k], vict[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < UC_SETS; s++) tree_q[s] <= '0;
        end else if (cm_valid) begin
            tree_q[cm_set] <= chain[cm_lines];
        end else if (hit_valid) begin
            tree_q[hit_set] <= plru_touch(tree_q[hit_set], hit_way);
        end
    end

    a_r7_distinct_ways: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && cm_lines > SEQ_W'(1)) |-> (vict[0] != vict[1]));
    a_r7_distinct_third: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && cm_lines > SEQ_W'(2)) |-> (vict[2] != vict[0] && vict[2] != vict[1]));
endmodule

// File: rtl/uc_store.sv
module uc_store
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inv,
    input  logic             cm_valid,
    input  logic [WIN_W-1:0] cm_win,
    input  logic [SEQ_W-1:0] cm_lines,
    input  line_t            cm_buf [UC_MAXL],
    input  logic [WAY_W-1:0] vict [UC_MAXL],
    input  logic             lk_valid,
    input  logic [WIN_W-1:0] lk_win,
    input  logic [SEQ_W-1:0] lk_seq,
    output logic             rd_hit,
    output line_t            rd_line,
    output logic             rd_last,
    output logic [IDX_W-1:0] hit_set,
    output logic [WAY_W-1:0] hit_way
);
    ent_t               ent_q [UC_SETS][UC_WAYS];
    logic [UC_WAYS-1:0] vld_q [UC_SETS];
    logic [UC_WAYS-1:0] vld_new, match;
    logic [IDX_W-1:0]   cm_set, lk_set;
    logic [TAG_W-1:0]   cm_tag, lk_tag;
    logic [WAY_W-1:0]   sel;

    assign cm_set = cm_win[IDX_W-1:0];
    assign cm_tag = cm_win[WIN_W-1:IDX_W];
    assign lk_set = lk_win[IDX_W-1:0];
    assign lk_tag = lk_win[WIN_W-1:IDX_W];

    // Stale lines of a re-filled window drop out as the new lines land.
    always_comb begin
        vld_new = vld_q[cm_set];
        for (int w = 0; w < UC_WAYS; w++)
            if (vld_new[w] && ent_q[cm_set][w].tag == cm_tag) vld_new[w] = 1'b0;
        for (int k = 0; k < UC_MAXL; k++)
            if (k < int'(cm_lines)) vld_new[vict[k]] = 1'b1;
    end

    always_comb begin
        sel = '0;
        for (int w = UC_WAYS - 1; w >= 0; w--) begin
            match[w] = vld_q[lk_set][w] && ent_q[lk_set][w].tag == lk_tag
                       && ent_q[lk_set][w].seq == lk_seq;
            if (match[w]) sel = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < UC_SETS; s++) vld_q[s] <= '0;
            rd_hit  <= 1'b0;
            rd_line <= '0;
            rd_last <= 1'b0;
            hit_set <= '0;
            hit_way <= '0;
        end else begin
            if (inv) begin
                for (int s = 0; s < UC_SETS; s++) vld_q[s] <= '0;
            end else if (cm_valid) begin
                vld_q[cm_set] <= vld_new;
            end
            rd_hit  <= lk_valid && (|match);
            rd_line <= ent_q[lk_set][sel].line;
            rd_last <= ent_q[lk_set][sel].last;
            hit_set <= lk_set;
            hit_way <= sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !inv && cm_valid) begin
            for (int k = 0; k < UC_MAXL; k++)
                if (k < int'(cm_lines))
                    ent_q[cm_set][vict[k]] <= '{tag: cm_tag, seq: SEQ_W'(k),
                                               last: (k == int'(cm_lines) - 1),
                                               line: cm_buf[k]};
        end
    end

    a_r7_single_match: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot0(match));
    a_r6_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rd_hit);
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (rd_line.cnt != '0 && int'(rd_line.cnt) <= UC_SLOTS));
endmodule

// File: rtl/uop_cache.sv
module uop_cache
    import uc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fl_start,
    input  logic [WIN_W-1:0]             fl_win,
    input  logic                         fl_ins,
    input  logic [CNT_W-1:0]             fl_cnt,
    input  logic                         fl_br,
    input  logic                         fl_end,
    input  logic [UC_SLOTS*UC_UOP_W-1:0] fl_uops,
    input  logic                         inv,
    input  logic                         lk_valid,
    input  logic [WIN_W-1:0]             lk_win,
    input  logic [SEQ_W-1:0]             lk_seq,
    output logic                         rd_hit,
    output logic [CNT_W-1:0]             rd_cnt,
    output logic                         rd_br,
    output logic                         rd_last,
    output logic [UC_SLOTS*UC_UOP_W-1:0] rd_uops
);
    toks_t            fl_toks;
    logic             cm_valid;
    logic [WIN_W-1:0] cm_win;
    logic [SEQ_W-1:0] cm_lines;
    line_t            cm_buf [UC_MAXL];
    logic [WAY_W-1:0] vict [UC_MAXL];
    line_t            rd_line;
    logic [IDX_W-1:0] hit_set;
    logic [WAY_W-1:0] hit_way;

    assign fl_toks = fl_uops;

    uc_packer u_pack (
        .clk(clk), .rst(rst), .inv(inv), .start(fl_start), .start_win(fl_win),
        .ins(fl_ins), .cnt(fl_cnt), .br(fl_br), .last(fl_end), .toks(fl_toks),
        .cm_valid(cm_valid), .cm_win(cm_win), .cm_lines(cm_lines), .cm_buf(cm_buf)
    );

    uc_repl u_repl (
        .clk(clk), .rst(rst), .cm_valid(cm_valid && !inv),
        .cm_set(cm_win[IDX_W-1:0]), .cm_lines(cm_lines),
        .hit_valid(rd_hit), .hit_set(hit_set), .hit_way(hit_way), .vict(vict)
    );

    uc_store u_store (
        .clk(clk), .rst(rst), .inv(inv), .cm_valid(cm_valid), .cm_win(cm_win),
        .cm_lines(cm_lines), .cm_buf(cm_buf), .vict(vict), .lk_valid(lk_valid),
        .lk_win(lk_win), .lk_seq(lk_seq), .rd_hit(rd_hit), .rd_line(rd_line),
        .rd_last(rd_last), .hit_set(hit_set), .hit_way(hit_way)
    );

    assign rd_cnt  = rd_line.cnt;
    assign rd_br   = rd_line.br;
    assign rd_uops = rd_line.toks;

    a_r9_inv_flush: assert property (@(posedge clk) disable iff (rst)
        inv |-> ##2 !rd_hit);
endmodule

// File: tb/uop_cache_tb_top.sv
`timescale 1ns/1ps
module uop_cache_tb_top;
    import uc_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic                         fl_start = 1'b0, fl_ins = 1'b0, fl_br = 1'b0, fl_end = 1'b0;
    logic [WIN_W-1:0]             fl_win = '0, lk_win = '0;
    logic [CNT_W-1:0]             fl_cnt = '0;
    logic [UC_SLOTS*UC_UOP_W-1:0] fl_uops = '0;
    logic                         inv = 1'b0, lk_valid = 1'b0;
    logic [SEQ_W-1:0]             lk_seq = '0;
    logic                         rd_hit, rd_br, rd_last;
    logic [CNT_W-1:0]             rd_cnt;
    logic [UC_SLOTS*UC_UOP_W-1:0] rd_uops;

    int vecs = 0, fails = 0;
    int d_c [8];
    bit d_b [8];
    int m_cnt [3];
    bit m_br [3];
    int m_tok [3][6];
    int m_cur, m_lines;
    bit m_closed, m_rej;

    always #2 clk = ~clk;

    uop_cache dut_i (
        .clk(clk), .rst(rst), .fl_start(fl_start), .fl_win(fl_win), .fl_ins(fl_ins),
        .fl_cnt(fl_cnt), .fl_br(fl_br), .fl_end(fl_end), .fl_uops(fl_uops), .inv(inv),
        .lk_valid(lk_valid), .lk_win(lk_win), .lk_seq(lk_seq), .rd_hit(rd_hit),
        .rd_cnt(rd_cnt), .rd_br(rd_br), .rd_last(rd_last), .rd_uops(rd_uops)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < 3; l++) begin m_cnt[l] = 0; m_br[l] = 0; end
        m_cur = 0; m_closed = 0; m_rej = 0; m_lines = 1;
    endtask

    task automatic model_ins(input int c, input bit b, input int tb);
        int base, put, t;
        bit newl;
        if (m_rej) return;
        base = m_cnt[m_cur];
        newl = (base != 0) && (m_closed || base + c > UC_SLOTS);
        t = m_cur + (newl ? 1 : 0);
        if (c == 0 || c > UC_SLOTS || t >= UC_MAXL) begin
            m_rej = 1;
        end else begin
            put = newl ? 0 : base;
            for (int j = 0; j < c; j++) m_tok[t][put + j] = (tb + j) & 16'hffff;
            m_cnt[t] = put + c; m_br[t] = b; m_closed = b; m_cur = t;
            m_lines = m_cur + 1;
        end
    endtask

    task automatic do_start(input int win);
        fl_start = 1'b1; fl_win = WIN_W'(win);
        tick();
        fl_start = 1'b0;
    endtask

    task automatic do_ins(input int c, input bit b, input bit e, input int tb);
        fl_ins = 1'b1; fl_cnt = CNT_W'(c); fl_br = b; fl_end = e;
        for (int j = 0; j < UC_SLOTS; j++) fl_uops[j*UC_UOP_W +: UC_UOP_W] = UC_UOP_W'(tb + j);
        tick();
        fl_ins = 1'b0; fl_end = 1'b0; fl_br = 1'b0;
    endtask

    task automatic fill_seq(input int win, input int n);
        model_reset();
        do_start(win);
        for (int i = 0; i < n; i++) begin
            model_ins(d_c[i], d_b[i], win * 13 + i * 6);
            do_ins(d_c[i], d_b[i], i == n - 1, win * 13 + i * 6);
        end
        tick();
    endtask

    task automatic look(input int win, input int seq);
        lk_valid = 1'b1; lk_win = WIN_W'(win); lk_seq = SEQ_W'(seq);
        tick();
        lk_valid = 1'b0;
    endtask

    task automatic verify(input int win, input string tag);
        for (int s = 0; s < 3; s++) begin
            bit eh, ok;
            eh = !m_rej && s < m_lines;
            look(win, s);
            chk(rd_hit == eh, tag, "hit", rd_hit, eh);
            if (eh && rd_hit) begin
                chk(rd_cnt == CNT_W'(m_cnt[s]), "R3", "line count", rd_cnt, m_cnt[s]);
                chk(rd_br == m_br[s], "R4", "branch flag", rd_br, m_br[s]);
                chk(rd_last == (s == m_lines - 1), "R6", "last flag", rd_last, s == m_lines - 1);
                ok = 1;
                for (int j = 0; j < m_cnt[s]; j++)
                    if (rd_uops[j*UC_UOP_W +: UC_UOP_W] != UC_UOP_W'(m_tok[s][j])) ok = 0;
                chk(ok, "R6", "payload", ok, 1);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: empty after reset
        look(5, 0);  chk(rd_hit == 1'b0, "R1", "hit after reset", rd_hit, 0);
        look(0, 2);  chk(rd_hit == 1'b0, "R1", "hit after reset", rd_hit, 0);

        // Sweep of instruction mixes, one window per pattern
        for (int p = 0; p < 64; p++) begin
            int n;
            n = 1 + p % 6;
            for (int i = 0; i < n; i++) begin
                d_c[i] = 1 + (p * 5 + i * 3) % 6;
                d_b[i] = ((p + 2 * i) % 7 == 3);
            end
            if (p % 19 == 18) d_c[n-1] = 7;   // R10
            if (p % 23 == 22) d_c[0] = 0;     // R10
            fill_seq(p, n);
            verify(p, m_rej ? "R5" : "R6");
        end

        // R3: no split, counts 4 then 3 give two lines
        d_c[0] = 4; d_b[0] = 0; d_c[1] = 3; d_b[1] = 0;
        fill_seq(200, 2); verify(200, "R3");
        chk(m_lines == 2, "R3", "model lines", m_lines, 2);
        // R2: same set, other tag misses
        look(200 + UC_SETS, 0); chk(rd_hit == 1'b0, "R2", "alias hit", rd_hit, 0);
        look(200 + 1, 0);       chk(rd_hit == 1'b0, "R2", "neighbour set hit", rd_hit, 0);
        // R3: three small instructions share one line
        d_c[0] = 2; d_c[1] = 2; d_c[2] = 2; d_b[0] = 0; d_b[1] = 0; d_b[2] = 0;
        fill_seq(201, 3); verify(201, "R3");
        // R4: branch closes a half-empty line
        d_c[0] = 2; d_b[0] = 1; d_c[1] = 1; d_b[1] = 0;
        fill_seq(202, 2); verify(202, "R4");

        // R5: a rejected re-fill leaves the cached line alone
        d_c[0] = 3; d_b[0] = 0;
        fill_seq(300, 1); verify(300, "R6");
        d_c[0] = 6; d_c[1] = 6; d_c[2] = 6; d_c[3] = 1;
        d_b[0] = 0; d_b[1] = 0; d_b[2] = 0; d_b[3] = 0;
        fill_seq(300, 4);
        look(300, 0);
        chk(rd_hit == 1'b1, "R5", "old line kept", rd_hit, 1);
        chk(rd_cnt == 3, "R5", "old count", rd_cnt, 3);
        chk(rd_uops[UC_UOP_W-1:0] == UC_UOP_W'(300 * 13), "R5", "old token",
            rd_uops[UC_UOP_W-1:0], 300 * 13);

        // R7: re-fill drops stale lines
        d_c[0] = 6; d_c[1] = 6; d_c[2] = 6;
        fill_seq(400, 3); verify(400, "R7");
        d_c[0] = 2;
        fill_seq(400, 1); verify(400, "R7");

        // R10: illegal counts
        d_c[0] = 0; fill_seq(700, 1); verify(700, "R10");
        d_c[0] = 7; fill_seq(701, 1); verify(701, "R10");

        // R6: back-to-back lookups, one line per cycle
        d_c[0] = 5; d_c[1] = 5; d_b[0] = 0; d_b[1] = 0;
        fill_seq(500, 2);
        lk_valid = 1'b1; lk_win = WIN_W'(500); lk_seq = 0;
        tick();
        chk(rd_hit && rd_cnt == 5 && !rd_last, "R6", "first of pair", rd_hit, 1);
        lk_seq = 1;
        tick();
        chk(rd_hit && rd_cnt == 5 && rd_last, "R6", "second of pair", rd_hit, 1);
        lk_valid = 1'b0;
        tick();
        chk(rd_hit == 1'b0, "R6", "idle cycle", rd_hit, 0);

        // R9: invalidate mid-fill
        do_start(600);
        do_ins(2, 0, 0, 1);
        inv = 1'b1; tick(); inv = 1'b0;
        do_ins(1, 0, 1, 2);
        tick();
        look(600, 0); chk(rd_hit == 1'b0, "R9", "abandoned fill", rd_hit, 0);
        look(500, 0); chk(rd_hit == 1'b0, "R9", "flushed line", rd_hit, 0);
        look(200, 0); chk(rd_hit == 1'b0, "R9", "flushed line", rd_hit, 0);

        // R8: nine single-line windows into set 7, no lookups between fills
        for (int k = 1; k <= 9; k++) begin
            d_c[0] = 1; d_b[0] = 0;
            fill_seq(7 + UC_SETS * k, 1);
        end
        look(7 + UC_SETS, 0);
        chk(rd_hit == 1'b0, "R8", "oldest evicted", rd_hit, 0);
        for (int k = 2; k <= 9; k++) begin
            look(7 + UC_SETS * k, 0);
            chk(rd_hit == 1'b1, "R8", "survivor", rd_hit, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule